// File: doc/BRIEF.md
# Configurable Output Macrocell Bank

This block is a bank of output macrocells that sit between a sum-of-products logic array and the bidirectional pins of a programmable logic block. Each cell takes its own sum-of-products term, its own output-enable term and a two-bit configuration. That configuration decides two things. One is whether the sum is captured in a flip-flop or passed straight through. The other is whether the pin shows the value true or inverted. Every cell also returns a feedback bit to the array. In registered mode this bit is the flip-flop state. In combinatorial mode it is whatever is present on the pin.

Two control terms are shared by every cell in the bank. The clear term empties all flip-flops at once, without waiting for a clock. The set term loads ones into them, but only at a rising clock edge. When both are active, the clear wins. A synchronous active-low reset models the power-on initialisation that leaves every flip-flop at 0. The pin is modelled by three separate signals: the value driven out, the drive enable, and the value seen on the pad.

Top module: `mc_bank`

## Requirements
- R1: Configuration {cfg_comb,cfg_pol_high} = 2'b00 is registered with active-low output: pin_out equals the inverse of the cell's flip-flop state.
- R2: Configuration 2'b01 is registered with active-high output: pin_out equals the flip-flop state.
- R3: Configuration 2'b10 drives pin_out with the inverse of sop, and 2'b11 drives it with sop. Both are combinatorial, so pin_out changes in the same cycle with no clock edge.
- R4: In registered mode, each rising clock edge loads sop into the flip-flop, provided no reset, clear or set is active. fb then equals the flip-flop state, whatever the values of pin_in and oe_term.
- R5: In combinatorial mode, fb equals pin_out while oe_term is 1, and equals pin_in while oe_term is 0.
- R6: While ar_term is 1, every flip-flop reads 0 at once, before any clock edge, and stays 0 across clock edges.
- R7: sp_term set to 1 loads 1 into every flip-flop at the next rising clock edge. It has no effect before that edge.
- R8: When ar_term and sp_term are both 1 at a clock edge, the flip-flops stay 0.
- R9: rst_n low at a rising clock edge clears every flip-flop. After reset, an active-low registered cell drives 1 and an active-high registered cell drives 0.
- R10: pin_oe follows oe_term in every configuration.
- R11: ar_term and sp_term act on all cells of the bank together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; flip-flops capture on the rising edge |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| ar_term | input | 1 | Shared asynchronous clear term, active high |
| sp_term | input | 1 | Shared synchronous set term, active high |
| sop | input | N_CELLS | Sum-of-products term per cell |
| oe_term | input | N_CELLS | Output-enable term per cell |
| pin_in | input | N_CELLS | Value present on each pad |
| cfg_comb | input | N_CELLS | Per cell: 1 = combinatorial, 0 = registered |
| cfg_pol_high | input | N_CELLS | Per cell: 1 = active-high, 0 = active-low |
| pin_out | output | N_CELLS | Value each cell drives toward its pad |
| pin_oe | output | N_CELLS | Pad drive enable per cell |
| fb | output | N_CELLS | Feedback to the logic array per cell |

## Verification
The properties assume three things about the inputs. ar_term and all other inputs change only between clock edges, never on one. A raised ar_term is held until at least the following rising edge. The configuration of a cell is not changed in the same cycle as a check that depends on it. The directed tasks meet these assumptions by changing inputs a couple of nanoseconds after a rising edge. They keep clear pulses across an edge, and they change the configuration only between scenarios, before re-establishing a known register state.

// File: rtl/mc_pkg.sv
// Package for the output macrocell bank.
// Holds the configuration encoding: the upper bit selects the combinatorial
// path and the lower bit selects active-high polarity.
package mc_pkg;

    typedef enum logic [1:0] {
        CFG_REG_LO = 2'b00,
        CFG_REG_HI = 2'b01,
        CFG_CMB_LO = 2'b10,
        CFG_CMB_HI = 2'b11
    } mc_cfg_e;

    // True when the configuration bypasses the flip-flop.
    function automatic logic cfg_is_comb(mc_cfg_e c);
        return (c == CFG_CMB_LO) || (c == CFG_CMB_HI);
    endfunction

endpackage

// File: rtl/mc_state_reg.sv
// Macrocell state flip-flop.
// Clears asynchronously on ar. Otherwise, on a rising clock edge it clears on
// rst_n low, sets on sp, or loads d. The clear term outranks everything.
// Assumes that ar is free of glitches and comes from the shared array term.
module mc_state_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic ar,
    input  logic sp,
    input  logic d,
    output logic q
);

    // State update: async clear, then sync reset, sync set, data load.
    always_ff @(posedge clk or posedge ar) begin
        if (ar) begin
            q <= 1'b0;
        end else if (!rst_n) begin
            q <= 1'b0;
        end else if (sp) begin
            q <= 1'b1;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/mc_output_sel.sv
// Macrocell output and feedback selection.
// Picks the flip-flop state or the raw sum, applies the selected polarity and
// chooses the feedback source. Purely combinational.
// Assumes that cfg is held stable by configuration storage outside the block.
module mc_output_sel
    import mc_pkg::*;
(
    input  mc_cfg_e cfg,
    input  logic    q,
    input  logic    sop,
    input  logic    oe,
    input  logic    pin_in,
    output logic    pin_out,
    output logic    pin_oe,
    output logic    fb
);

    logic data_sel;

    // Data source and polarity according to the configuration.
    always_comb begin
        unique case (cfg)
            CFG_REG_LO: data_sel = ~q;
            CFG_REG_HI: data_sel = q;
            CFG_CMB_LO: data_sel = ~sop;
            CFG_CMB_HI: data_sel = sop;
            default:    data_sel = ~q;
        endcase
    end

    // Feedback: register state, or what is on the pad in combinatorial mode.
    always_comb begin
        if (!cfg_is_comb(cfg)) begin
            fb = q;
        end else if (oe) begin
            fb = data_sel;
        end else begin
            fb = pin_in;
        end
    end

    assign pin_out = data_sel;
    assign pin_oe  = oe;

endmodule

// File: rtl/mc_cell.sv
// One output macrocell: a state flip-flop followed by output selection.
// Assumes that the shared clear and set terms are distributed by the parent.
module mc_cell
    import mc_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    ar,
    input  logic    sp,
    input  mc_cfg_e cfg,
    input  logic    sop,
    input  logic    oe,
    input  logic    pin_in,
    output logic    pin_out,
    output logic    pin_oe,
    output logic    fb
);

    logic q;

    mc_state_reg u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .ar    (ar),
        .sp    (sp),
        .d     (sop),
        .q     (q)
    );

    mc_output_sel u_sel (
        .cfg     (cfg),
        .q       (q),
        .sop     (sop),
        .oe      (oe),
        .pin_in  (pin_in),
        .pin_out (pin_out),
        .pin_oe  (pin_oe),
        .fb      (fb)
    );

endmodule

// File: rtl/mc_bank.sv
// Bank of N_CELLS output macrocells that share one clear term and one set term.
// Each cell has its own configuration, sum term, enable term and pad.
// Assumes that all inputs are synchronous to clk, except ar_term.
module mc_bank
    import mc_pkg::*;
#(
    parameter int N_CELLS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ar_term,
    input  logic               sp_term,
    input  logic [N_CELLS-1:0] sop,
    input  logic [N_CELLS-1:0] oe_term,
    input  logic [N_CELLS-1:0] pin_in,
    input  logic [N_CELLS-1:0] cfg_comb,
    input  logic [N_CELLS-1:0] cfg_pol_high,
    output logic [N_CELLS-1:0] pin_out,
    output logic [N_CELLS-1:0] pin_oe,
    output logic [N_CELLS-1:0] fb
);

    // One macrocell for each output, with its configuration bits packed.
    for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
        mc_cfg_e cell_cfg;
        assign cell_cfg = mc_cfg_e'({cfg_comb[i], cfg_pol_high[i]});

        mc_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .ar      (ar_term),
            .sp      (sp_term),
            .cfg     (cell_cfg),
            .sop     (sop[i]),
            .oe      (oe_term[i]),
            .pin_in  (pin_in[i]),
            .pin_out (pin_out[i]),
            .pin_oe  (pin_oe[i]),
            .fb      (fb[i])
        );
    end

endmodule

// File: rtl/mc_bank_chk.sv
// Checker for mc_bank, attached through bind. It observes ports only.
// Assumes that inputs change away from clock edges and that ar_term, once
// raised, is held through the next rising edge.
module mc_bank_chk #(
    parameter int N_CELLS = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ar_term,
    input logic               sp_term,
    input logic [N_CELLS-1:0] sop,
    input logic [N_CELLS-1:0] oe_term,
    input logic [N_CELLS-1:0] pin_in,
    input logic [N_CELLS-1:0] cfg_comb,
    input logic [N_CELLS-1:0] cfg_pol_high,
    input logic [N_CELLS-1:0] pin_out,
    input logic [N_CELLS-1:0] pin_oe,
    input logic [N_CELLS-1:0] fb
);

    for (genvar i = 0; i < N_CELLS; i++) begin : g_chk
        p_reg_lo_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (!cfg_comb[i] && !cfg_pol_high[i]) |-> (pin_out[i] == !fb[i]));

        p_reg_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (!cfg_comb[i] && cfg_pol_high[i]) |-> (pin_out[i] == fb[i]));

        p_comb_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_comb[i] |-> (pin_out[i] == (cfg_pol_high[i] ? sop[i] : !sop[i])));

        p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (!cfg_comb[i] && !ar_term && !sp_term) |=>
            (ar_term || cfg_comb[i] || fb[i] == $past(sop[i])));

        p_comb_fb_r5: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_comb[i] |-> (fb[i] == (oe_term[i] ? pin_out[i] : pin_in[i])));

        p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (ar_term && !cfg_comb[i]) |-> (fb[i] == 1'b0));

        p_preset_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (sp_term && !ar_term && !cfg_comb[i]) |=>
            (ar_term || cfg_comb[i] || fb[i] == 1'b1));

        p_reset_r9: assert property (@(posedge clk)
            (!rst_n && !ar_term && !cfg_comb[i]) |=>
            (ar_term || cfg_comb[i] || !rst_n || fb[i] == 1'b0));

        p_oe_r10: assert property (@(posedge clk) disable iff (!rst_n)
            pin_oe[i] == oe_term[i]);
    end

endmodule

bind mc_bank mc_bank_chk #(.N_CELLS(N_CELLS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ar_term      (ar_term),
    .sp_term      (sp_term),
    .sop          (sop),
    .oe_term      (oe_term),
    .pin_in       (pin_in),
    .cfg_comb     (cfg_comb),
    .cfg_pol_high (cfg_pol_high),
    .pin_out      (pin_out),
    .pin_oe       (pin_oe),
    .fb           (fb)
);

// File: tb/sim_mc_bank.sv
// Directed bench for mc_bank: one task per scenario, each checks its results.
module sim_mc_bank;

    localparam int N = 4;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         ar_term;
    logic         sp_term;
    logic [N-1:0] sop;
    logic [N-1:0] oe_term;
    logic [N-1:0] pin_in;
    logic [N-1:0] cfg_comb;
    logic [N-1:0] cfg_pol_high;
    logic [N-1:0] pin_out;
    logic [N-1:0] pin_oe;
    logic [N-1:0] fb;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    mc_bank #(.N_CELLS(N)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .ar_term      (ar_term),
        .sp_term      (sp_term),
        .sop          (sop),
        .oe_term      (oe_term),
        .pin_in       (pin_in),
        .cfg_comb     (cfg_comb),
        .cfg_pol_high (cfg_pol_high),
        .pin_out      (pin_out),
        .pin_oe       (pin_oe),
        .fb           (fb)
    );

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // One clock edge, then settle 2 ns past it.
    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    // Pin value expected for a registered cell with state q.
    function automatic logic [N-1:0] reg_pin(input logic [N-1:0] q, input logic [N-1:0] pol);
        return (q & pol) | (~q & ~pol);
    endfunction

    task automatic t_reset();
        rst_n = 1'b0; ar_term = 1'b0; sp_term = 1'b0;
        sop = '1; oe_term = '1; pin_in = '0;
        cfg_comb = '0; cfg_pol_high = 4'b1010;
        tick(); tick();
        chk("R9 reset fb", fb, 4'b0000);
        chk("R9 reset pin_out", pin_out, 4'b0101);
        rst_n = 1'b1;
    endtask

    task automatic t_reg_capture();
        cfg_comb = '0; cfg_pol_high = 4'b1010; oe_term = '0;
        sop = 4'b1011; pin_in = 4'b0100;
        #1;
        chk("R4 no change before edge", fb, 4'b0000);
        tick();
        chk("R4 capture fb", fb, 4'b1011);
        chk("R1 R2 registered pin", pin_out, reg_pin(4'b1011, 4'b1010));
        sop = 4'b0110; pin_in = 4'b1001; oe_term = 4'b0101;
        tick();
        chk("R4 capture fb ignores pad", fb, 4'b0110);
        chk("R1 R2 registered pin 2", pin_out, reg_pin(4'b0110, 4'b1010));
        cfg_pol_high = '0;
        #1;
        chk("R1 all active-low", pin_out, 4'b1001);
        cfg_pol_high = '1;
        #1;
        chk("R2 all active-high", pin_out, 4'b0110);
    endtask

    task automatic t_comb();
        cfg_comb = '1; cfg_pol_high = 4'b1100;
        sop = 4'b0110; oe_term = '1;
        #1;
        chk("R3 comb pin", pin_out, 4'b0101);
        chk("R5 comb fb enabled", fb, 4'b0101);
        oe_term = 4'b0101; pin_in = 4'b0011;
        #1;
        chk("R5 comb fb mixed", fb, 4'b0111);
        chk("R10 pin_oe", pin_oe, 4'b0101);
        sop = 4'b1001;
        #1;
        chk("R3 comb pin no clock", pin_out, 4'b1010);
    endtask

    task automatic t_async_clear();
        cfg_comb = '0; cfg_pol_high = '1; oe_term = '1;
        sop = '1;
        tick();
        chk("R4 load ones", fb, 4'b1111);
        #1 ar_term = 1'b1;
        #1;
        chk("R6 R11 clear before edge", fb, 4'b0000);
        chk("R6 clear pin", pin_out, 4'b0000);
        tick();
        chk("R6 held through edge", fb, 4'b0000);
        ar_term = 1'b0;
    endtask

    task automatic t_preset();
        sop = '0; sp_term = 1'b1;
        #1;
        chk("R7 no set before edge", fb, 4'b0000);
        tick();
        chk("R7 R11 set at edge", fb, 4'b1111);
        sp_term = 1'b0;
        tick();
        chk("R4 load after set", fb, 4'b0000);
    endtask

    task automatic t_priority();
        sop = '1;
        tick();
        ar_term = 1'b1; sp_term = 1'b1;
        tick();
        chk("R8 clear beats set", fb, 4'b0000);
        ar_term = 1'b0; sp_term = 1'b0;
        sop = 4'b0010;
        tick();
        chk("R8 recovery load", fb, 4'b0010);
    endtask

    task automatic t_sweep();
        logic [N-1:0] q_exp;
        sop = '0; cfg_comb = '0;
        tick();
        q_exp = '0;
        for (int c = 0; c < 4; c++) begin
            cfg_comb = {N{c[1]}};
            cfg_pol_high = {N{c[0]}};
            for (int k = 0; k < 6; k++) begin
                logic [N-1:0] p;
                logic [N-1:0] exp_out;
                logic [N-1:0] exp_fb;
                oe_term = N'(k * 5 + c);
                pin_in = N'(k * 3 + 1);
                sop = N'(k * 7 + c * 2 + 1);
                tick();
                q_exp = sop;
                p = cfg_pol_high;
                if (c[1]) begin
                    exp_out = reg_pin(sop, p);
                    exp_fb = (oe_term & exp_out) | (~oe_term & pin_in);
                    chk("R3 R5 sweep comb", {pin_out, fb} >> N, exp_out);
                    chk("R5 sweep comb fb", fb, exp_fb);
                end else begin
                    chk("R4 sweep reg fb", fb, q_exp);
                    chk("R1 R2 sweep reg pin", pin_out, reg_pin(q_exp, p));
                end
                chk("R10 sweep oe", pin_oe, oe_term);
            end
        end
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; ar_term = 1'b0; sp_term = 1'b0;
        sop = '0; oe_term = '0; pin_in = '0;
        cfg_comb = '0; cfg_pol_high = '0;
        #2;
        t_reset();
        t_reg_capture();
        t_comb();
        t_async_clear();
        t_preset();
        t_priority();
        t_sweep();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule